// File: doc/BRIEF.md
# Checked Result Buffer with In-Order Retirement

This block runs beside a reorder buffer in a pipeline that executes every instruction twice. At dispatch an entry is allocated in a circular buffer and its tag is handed back. When the primary pipeline finishes an instruction, its result is written into that entry. Later a checker pipeline recomputes the same instruction and writes its result against the same tag. The two values are compared on arrival, and only the one-bit verdict is kept.

Each cycle the block scans up to `RET_W` consecutive entries, starting at the oldest. Entries that are checked and agree leave in program order. The scan stops at the first entry that is not ready. If that first blocking entry is checked but disagrees, the block pulses a restart exception carrying the entry's tag. Any older ready entries in front of it still retire in the same cycle, and the whole buffer is then emptied, so the front end can restart at the faulty instruction.

Back-pressure applies only on the allocate side. `alloc_ready` drops when every entry is occupied and during the exception cycle. A dispatch happens only in a cycle where both `alloc_valid` and `alloc_ready` are high. Result writes and the retire output have no back-pressure: writes are always sampled, and retired lanes are final in the cycle they are shown.

Top module: `checked_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `ret_num`=0, `ret_vld`=0, `exc_valid`=0.
- R2: Accepted allocations receive consecutive tags (`alloc_tag`), wrapping modulo DEPTH.
- R3: With DEPTH entries occupied, `alloc_ready` is 0 and an offered allocation is not taken; it returns to 1 once retirement frees an entry.
- R4: An entry with only its primary result recorded never retires; it retires only after a checker result equal to the primary value has been written.
- R5: Retirement is strictly in program order: a checked younger entry waits while any older entry is unchecked.
- R6: At most RET_W entries retire per cycle. `ret_vld` is a run of ones from lane 0 whose length is `ret_num`. Lane k carries tag (`ret_tag`+k) mod DEPTH in `ret_tag` order and carries that entry's primary value in `ret_data[k*DATA_W +: DATA_W]`.
- R7: When the oldest non-retiring entry in the scan window is checked but its two results differ, `exc_valid` is high for exactly one cycle and `exc_tag` gives that entry. Older ready entries retire in that same cycle, no younger entry retires, and `alloc_ready` is 0.
- R8: After an exception the buffer is empty, and the next allocation receives tag 0.
- R9: A checker write to an entry without a recorded primary result drives `chk_err` high in that cycle and is otherwise ignored. Such an entry does not retire once its primary result arrives without a new checker write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests an entry |
| alloc_ready | output | 1 | Entry available this cycle |
| alloc_tag | output | $clog2(DEPTH) | Tag assigned to the accepted allocation |
| pri_valid | input | 1 | Primary result write strobe |
| pri_tag | input | $clog2(DEPTH) | Entry of the primary result |
| pri_data | input | DATA_W | Primary result value |
| chk_valid | input | 1 | Checker result write strobe |
| chk_tag | input | $clog2(DEPTH) | Entry of the checker result |
| chk_data | input | DATA_W | Recomputed result value |
| chk_err | output | 1 | Checker write hit an entry lacking its primary result |
| ret_vld | output | RET_W | Per-lane retire flags, contiguous from lane 0 |
| ret_num | output | $clog2(RET_W+1) | Number of entries retiring this cycle |
| ret_tag | output | $clog2(DEPTH) | Tag in lane 0 (oldest entry) |
| ret_data | output | RET_W*DATA_W | Primary values of the retiring lanes |
| exc_valid | output | 1 | Restart exception pulse |
| exc_tag | output | $clog2(DEPTH) | Tag of the mismatching entry |

## Verification
The assertions assume the surrounding pipelines are well behaved. A primary result is written only to an allocated entry, once, and never in the cycle that entry is allocated. A checker result follows its primary by at least one cycle. The random stimulus keeps to these rules by picking write targets from its own model of which entries hold which results. Rule breaking is exercised only in the single directed case for `chk_err`.

// File: rtl/crb_pkg.sv
package crb_pkg;
  // Per-entry status bits.
  typedef struct packed {
    logic used;   // entry holds an in-flight instruction
    logic pdone;  // primary result recorded
    logic chkd;   // checker result compared
    logic bad;    // comparison found a difference
  } crb_flags_t;

  localparam crb_flags_t CRB_FRESH = '{used: 1'b1, pdone: 1'b0, chkd: 1'b0, bad: 1'b0};
endpackage

// File: rtl/crb_ptrs.sv
module crb_ptrs #(
  parameter int DEPTH = 32,
  parameter int RET_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_fire,
  input  logic [$clog2(RET_W+1)-1:0] ret_num,
  input  logic                       flush,
  output logic [$clog2(DEPTH)-1:0]   head,
  output logic [$clog2(DEPTH)-1:0]   tail,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full
);
  localparam int TW = $clog2(DEPTH);

  assign full = (count == (TW+1)'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head + TW'(ret_num);
      tail  <= tail + TW'(alloc_fire);
      count <= count + (TW+1)'(alloc_fire) - (TW+1)'(ret_num);
    end
  end

  assert_no_alloc_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && head == '0 && tail == '0));

  assert_head_follows_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_num != '0 && !flush) |=> head == TW'($past(head) + TW'($past(ret_num))));
endmodule

// File: rtl/crb_store.sv
module crb_store
  import crb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     alloc_fire,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic                     pri_valid,
  input  logic [$clog2(DEPTH)-1:0] pri_tag,
  input  logic [DATA_W-1:0]        pri_data,
  input  logic                     chk_valid,
  input  logic [$clog2(DEPTH)-1:0] chk_tag,
  input  logic [DATA_W-1:0]        chk_data,
  input  logic [DEPTH-1:0]         clr_mask,
  output crb_flags_t               flags [DEPTH],
  output logic [DATA_W-1:0]        pval  [DEPTH],
  output logic                     chk_err
);
  logic pri_ok, chk_ok;

  assign pri_ok  = pri_valid && flags[pri_tag].used && !flush;
  assign chk_ok  = chk_valid && flags[chk_tag].used && flags[chk_tag].pdone && !flush;
  assign chk_err = chk_valid && !(flags[chk_tag].used && flags[chk_tag].pdone);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clr_mask[i]) flags[i].used <= 1'b0;
        if (alloc_fire && alloc_idx == i[$clog2(DEPTH)-1:0]) flags[i] <= CRB_FRESH;
        if (pri_ok && pri_tag == i[$clog2(DEPTH)-1:0]) flags[i].pdone <= 1'b1;
        if (chk_ok && chk_tag == i[$clog2(DEPTH)-1:0]) begin
          flags[i].chkd <= 1'b1;
          flags[i].bad  <= (chk_data != pval[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pri_ok) pval[pri_tag] <= pri_data;
  end

  assert_err_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_err && flags[chk_tag].used && !flush) |=> !flags[$past(chk_tag)].chkd);

  assert_check_follows_primary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok && !flush) |=> (flags[$past(chk_tag)].chkd && flags[$past(chk_tag)].pdone));
endmodule

// File: rtl/crb_scan.sv
module crb_scan
  import crb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int RET_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH)-1:0]   head,
  input  logic [$clog2(DEPTH):0]     count,
  input  crb_flags_t                 flags [DEPTH],
  input  logic [DATA_W-1:0]          pval  [DEPTH],
  output logic [RET_W-1:0]           ret_vld,
  output logic [$clog2(RET_W+1)-1:0] ret_num,
  output logic [RET_W*DATA_W-1:0]    ret_data,
  output logic [DEPTH-1:0]           clr_mask,
  output logic                       exc_fire,
  output logic [$clog2(DEPTH)-1:0]   exc_idx
);
  localparam int TW = $clog2(DEPTH);
  localparam int NW = $clog2(RET_W+1);

  logic [TW-1:0] lane_idx [RET_W];

  for (genvar k = 0; k < RET_W; k++) begin : g_lane
    assign lane_idx[k] = head + TW'(k);
    assign ret_data[k*DATA_W +: DATA_W] = pval[lane_idx[k]];
  end

  always_comb begin
    logic stop;
    stop     = 1'b0;
    ret_vld  = '0;
    ret_num  = '0;
    clr_mask = '0;
    exc_fire = 1'b0;
    exc_idx  = '0;
    for (int k = 0; k < RET_W; k++) begin
      if (!stop) begin
        if ((TW+1)'(k) < count && flags[lane_idx[k]].used && flags[lane_idx[k]].chkd) begin
          if (!flags[lane_idx[k]].bad) begin
            ret_vld[k]             = 1'b1;
            ret_num                = ret_num + NW'(1);
            clr_mask[lane_idx[k]]  = 1'b1;
          end else begin
            exc_fire = 1'b1;
            exc_idx  = lane_idx[k];
            stop     = 1'b1;
          end
        end else begin
          stop = 1'b1;
        end
      end
    end
  end

  logic [RET_W:0] run_plus_one;
  assign run_plus_one = {1'b0, ret_vld} + (RET_W+1)'(1);

  assert_lanes_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(run_plus_one) && $countones(ret_vld) == int'(ret_num));

  assert_exc_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> !exc_fire);
endmodule

// File: rtl/checked_retire_buf.sv
module checked_retire_buf
  import crb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int RET_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  output logic [$clog2(DEPTH)-1:0]   alloc_tag,
  input  logic                       pri_valid,
  input  logic [$clog2(DEPTH)-1:0]   pri_tag,
  input  logic [DATA_W-1:0]          pri_data,
  input  logic                       chk_valid,
  input  logic [$clog2(DEPTH)-1:0]   chk_tag,
  input  logic [DATA_W-1:0]          chk_data,
  output logic                       chk_err,
  output logic [RET_W-1:0]           ret_vld,
  output logic [$clog2(RET_W+1)-1:0] ret_num,
  output logic [$clog2(DEPTH)-1:0]   ret_tag,
  output logic [RET_W*DATA_W-1:0]    ret_data,
  output logic                       exc_valid,
  output logic [$clog2(DEPTH)-1:0]   exc_tag
);
  localparam int TW = $clog2(DEPTH);

  logic [TW-1:0]     head, tail;
  logic [TW:0]       count;
  logic              full, alloc_fire, exc_fire;
  logic [DEPTH-1:0]  clr_mask;
  crb_flags_t        flags [DEPTH];
  logic [DATA_W-1:0] pval  [DEPTH];

  assign alloc_ready = !full && !exc_fire;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign ret_tag     = head;
  assign exc_valid   = exc_fire;

  crb_ptrs #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .ret_num(ret_num),
    .flush(exc_fire), .head(head), .tail(tail), .count(count), .full(full)
  );

  crb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(exc_fire),
    .alloc_fire(alloc_fire), .alloc_idx(tail),
    .pri_valid(pri_valid), .pri_tag(pri_tag), .pri_data(pri_data),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_data(chk_data),
    .clr_mask(clr_mask), .flags(flags), .pval(pval), .chk_err(chk_err)
  );

  crb_scan #(.DEPTH(DEPTH), .RET_W(RET_W), .DATA_W(DATA_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .head(head), .count(count), .flags(flags), .pval(pval),
    .ret_vld(ret_vld), .ret_num(ret_num), .ret_data(ret_data), .clr_mask(clr_mask),
    .exc_fire(exc_fire), .exc_idx(exc_tag)
  );

  assert_no_retire_on_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (ret_num == '0 && !exc_valid));

  assert_exc_blocks_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !alloc_ready);
endmodule

// File: tb/checked_retire_buf_test.sv
module checked_retire_buf_test;
  localparam int D  = 32;
  localparam int RW = 8;
  localparam int DW = 32;
  localparam int TW = $clog2(D);
  localparam int NW = $clog2(RW+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic alloc_valid = 1'b0, pri_valid = 1'b0, chk_valid = 1'b0;
  logic [TW-1:0] pri_tag = '0, chk_tag = '0;
  logic [DW-1:0] pri_data = '0, chk_data = '0;
  logic alloc_ready, chk_err, exc_valid;
  logic [TW-1:0] alloc_tag, ret_tag, exc_tag;
  logic [RW-1:0] ret_vld;
  logic [NW-1:0] ret_num;
  logic [RW*DW-1:0] ret_data;

  checked_retire_buf #(.DEPTH(D), .RET_W(RW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .pri_valid(pri_valid), .pri_tag(pri_tag), .pri_data(pri_data),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_data(chk_data), .chk_err(chk_err),
    .ret_vld(ret_vld), .ret_num(ret_num), .ret_tag(ret_tag), .ret_data(ret_data),
    .exc_valid(exc_valid), .exc_tag(exc_tag)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // Bench model of the buffer contents
  bit            m_used [D];
  bit            m_pd   [D];
  bit            m_chk  [D];
  logic [DW-1:0] m_pv   [D];
  logic [DW-1:0] m_cv   [D];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  // Expected outputs for the current cycle
  int e_n; bit e_exc; int e_exc_tag;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void predict();
    bit stop = 1'b0;
    e_n = 0; e_exc = 1'b0; e_exc_tag = 0;
    for (int k = 0; k < RW; k++) begin
      int ix = (m_head + k) % D;
      if (!stop) begin
        if (k < m_cnt && m_used[ix] && m_chk[ix]) begin
          if (m_cv[ix] == m_pv[ix]) e_n++;
          else begin e_exc = 1'b1; e_exc_tag = ix; stop = 1'b1; end
        end else stop = 1'b1;
      end
    end
  endfunction

  task automatic cyc(input bit av, input bit pv, input int pt, input logic [DW-1:0] pd,
                     input bit cv, input int ct, input logic [DW-1:0] cd);
    bit e_ready, e_err;
    alloc_valid = av; pri_valid = pv; pri_tag = TW'(pt); pri_data = pd;
    chk_valid = cv; chk_tag = TW'(ct); chk_data = cd;
    #1;
    predict();
    e_ready = (m_cnt < D) && !e_exc;
    e_err   = cv && !(m_used[ct] && m_pd[ct]);
    check(alloc_ready == e_ready, "R3 alloc_ready", alloc_ready, e_ready);
    if (e_ready) check(alloc_tag == TW'(m_tail), "R2 alloc_tag", alloc_tag, m_tail);
    check(ret_num == NW'(e_n), "R5 ret_num", ret_num, e_n);
    check(ret_vld == RW'((1 << e_n) - 1), "R6 ret_vld", ret_vld, (1 << e_n) - 1);
    if (e_n > 0) check(ret_tag == TW'(m_head), "R6 ret_tag", ret_tag, m_head);
    for (int k = 0; k < e_n; k++) begin
      int ix = (m_head + k) % D;
      check(ret_data[k*DW +: DW] == m_pv[ix], "R6 ret_data", ret_data[k*DW +: DW], m_pv[ix]);
    end
    check(exc_valid == e_exc, "R7 exc_valid", exc_valid, e_exc);
    if (e_exc) check(exc_tag == TW'(e_exc_tag), "R7 exc_tag", exc_tag, e_exc_tag);
    check(chk_err == e_err, "R9 chk_err", chk_err, e_err);
    @(posedge clk);
    if (e_exc) begin
      for (int i = 0; i < D; i++) begin m_used[i] = 0; m_pd[i] = 0; m_chk[i] = 0; end
      m_head = 0; m_tail = 0; m_cnt = 0;
    end else begin
      for (int k = 0; k < e_n; k++) m_used[(m_head + k) % D] = 0;
      m_head = (m_head + e_n) % D;
      if (pv && m_used[pt]) begin m_pd[pt] = 1; m_pv[pt] = pd; end
      if (cv && m_used[ct] && m_pd[ct]) begin m_chk[ct] = 1; m_cv[ct] = cd; end
      if (av && e_ready) begin
        m_used[m_tail] = 1; m_pd[m_tail] = 0; m_chk[m_tail] = 0;
        m_tail = (m_tail + 1) % D;
      end
      m_cnt = m_cnt - e_n + ((av && e_ready) ? 1 : 0);
    end
    @(negedge clk);
  endtask

  task automatic idle();             cyc(0, 0, 0, '0, 0, 0, '0); endtask
  task automatic alloc();            cyc(1, 0, 0, '0, 0, 0, '0); endtask
  task automatic wpri(input int t);  cyc(0, 1, t, DW'(32'hA000 + t), 0, 0, '0); endtask
  task automatic wchk(input int t, input logic [DW-1:0] v); cyc(0, 0, 0, '0, 1, t, v); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd2718));
    for (int i = 0; i < D; i++) begin m_used[i] = 0; m_pd[i] = 0; m_chk[i] = 0; m_pv[i] = '0; m_cv[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    idle();

    // R4, R5: primary alone never retires, younger waits for older
    base = m_tail;
    repeat (3) alloc();
    for (int i = 0; i < 3; i++) wpri((base + i) % D);
    idle();
    wchk((base + 2) % D, DW'(32'hA000 + (base + 2) % D));
    idle();
    wchk(base, DW'(32'hA000 + base));
    wchk((base + 1) % D, DW'(32'hA000 + (base + 1) % D));
    idle();

    // R3, R6: fill, stall, then batched retirement
    base = m_tail;
    repeat (D) alloc();
    alloc();
    for (int i = 0; i < 10; i++) wpri((base + i) % D);
    for (int i = 9; i >= 1; i--) wchk((base + i) % D, DW'(32'hA000 + (base + i) % D));
    wchk(base, DW'(32'hA000 + base));
    idle();
    for (int i = 10; i < D; i++) begin
      wpri((base + i) % D);
      wchk((base + i) % D, DW'(32'hA000 + (base + i) % D));
    end
    idle();

    // R7, R8: mismatch in the middle of ready entries
    base = m_tail;
    repeat (4) alloc();
    for (int i = 0; i < 4; i++) wpri((base + i) % D);
    wchk((base + 3) % D, DW'(32'hA000 + (base + 3) % D));
    wchk((base + 2) % D, DW'(32'hDEAD));
    wchk((base + 1) % D, DW'(32'hA000 + (base + 1) % D));
    wchk(base, DW'(32'hA000 + base));
    idle();
    alloc();
    idle();

    // R9: checker before primary is flagged and ignored
    wchk(0, DW'(32'hA000));
    wpri(0);
    idle();
    wchk(0, DW'(32'hA000));
    idle();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit av, pv, cv;
      int pt, ct, st;
      logic [DW-1:0] pd, cd;
      av = ($urandom % 10) < 6;
      pv = 0; cv = 0; pt = 0; ct = 0;
      pd = $urandom; cd = '0;
      st = $urandom % D;
      for (int j = 0; j < D; j++) begin
        int ix = (st + j) % D;
        if (!pv && m_used[ix] && !m_pd[ix]) begin pv = ($urandom % 4) != 0; pt = ix; end
      end
      st = $urandom % D;
      for (int j = 0; j < D; j++) begin
        int ix = (st + j) % D;
        if (!cv && m_used[ix] && m_pd[ix] && !m_chk[ix]) begin cv = ($urandom % 3) != 0; ct = ix; end
      end
      if (cv) cd = (($urandom % 25) == 0) ? ~m_pv[ct] : m_pv[ct];
      cyc(av, pv, pt, pd, cv, ct, cd);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule